// File: doc/BRIEF.md
# Endian-Selectable Byte Lane Buffer

This block is a four-byte staging buffer between a 16-bit host data port and a byte-wide serial bus engine. The host loads transmit data with 16-bit writes, or an 8-bit write for a trailing odd byte. The engine takes those bytes out one at a time, earliest-written byte first. In the other direction the engine deposits received bytes into successive byte lanes, and each 16-bit host read removes two bytes. A control input sets the byte order inside every 16-bit host access.

Transmit and receive byte counts are kept apart and are visible as outputs. Every state-changing access also raises one-cycle event pulses: a transmit-underflow clear, a transmit-ready clear, a receive-overrun clear, a receive-ready clear, a single-byte flag, an access-ready flag and a kick. A status or control block can merge these pulses into its own registers. All counts and event pulses are registered, so they show the effect of an access in the cycle after the clock edge that samples it. Read data and the outgoing engine byte are combinational views of the current buffer.

Top module: `byte_lane_buf`

## Requirements
- R1: After reset, both counts are 0, every event output is low, and host read data is 0x0000.
- R2: A host 16-bit write is accepted when at most 2 transmit bytes are held. The buffer moves up by two lanes, the transmit count rises by 2, and txUnderflowClr pulses. txReadyClr pulses only when the new transmit count exceeds 2.
- R3: With bigEndian=1 a 16-bit write puts data[15:8] in lane 1 and data[7:0] in lane 0. With bigEndian=0 it puts data[7:0] in lane 1 and data[15:8] in lane 0.
- R4: An accepted 8-bit write (hostWrByte=1) moves the buffer up one lane, puts data[7:0] in lane 0, raises the transmit count by 1 and pulses txUnderflowClr.
- R5: When more than 2 transmit bytes are held, a host write of either width leaves the buffer and the transmit count unchanged and raises no txUnderflowClr.
- R6: txByte shows lane (txCount-1). A pop lowers the transmit count by 1, so bytes leave in the order they were written. A pop with txCount=0 is ignored.
- R7: A receive push ORs rxByte into the lane numbered by the receive count and then adds 1 to that count. A push with 4 bytes held is ignored.
- R8: hostRdData is {lane1,lane0} when bigEndian=0 and {lane0,lane1} when bigEndian=1.
- R9: A host read with rxCount=1 pulses singleByte and sets the count to 0. With rxCount above 2 it moves the buffer down two lanes, zero-filling the top. Any rxCount above 1 drops by 2. A read with rxCount=0 changes nothing.
- R10: A host read that leaves rxCount at 0 pulses rxReadyClr. It also pulses accessReady when masterOn=1 and dirTx=0.
- R11: Every host read pulses rxOverrunClr.
- R12: kick pulses after every host access, whether accepted or not, and stays low otherwise.
- R13: A host write takes precedence over a host read in the same cycle. Engine pops and pushes are ignored in any cycle that has a host access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bigEndian | input | 1 | Byte order select for 16-bit host accesses |
| masterOn | input | 1 | Controller currently owns the transfer |
| dirTx | input | 1 | Transfer direction, 1 = transmit |
| hostWrEn | input | 1 | Host data write strobe |
| hostWrByte | input | 1 | Host write is 8 bits wide |
| hostWrData | input | 16 | Host write data |
| hostRdEn | input | 1 | Host data read strobe |
| hostRdData | output | 16 | Host read data (lanes 1:0) |
| txPop | input | 1 | Engine takes a transmit byte |
| txByte | output | 8 | Next transmit byte |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| txCount | output | 3 | Transmit bytes held |
| rxCount | output | 3 | Receive bytes held |
| kick | output | 1 | Pulse after each host access |
| txUnderflowClr | output | 1 | Pulse: clear transmit underflow |
| txReadyClr | output | 1 | Pulse: clear transmit ready |
| rxOverrunClr | output | 1 | Pulse: clear receive overrun |
| rxReadyClr | output | 1 | Pulse: clear receive ready |
| singleByte | output | 1 | Pulse: read found a lone byte |
| accessReady | output | 1 | Pulse: receive transfer finished |

## Verification
Transmit loads are swept in both byte orders with full words, trailing single bytes and writes into a full buffer. The order in which popped bytes come out tells a correct lane mapping from a swapped one, and the overfull writes show that rejection leaves the contents intact. Receive runs push every count from zero to four, plus one push past full, and then read until the buffer is empty. This separates the shift-down path, the lone-byte path and the empty read, and it exposes the OR-into-lane behaviour on stale bytes. A sweep over masterOn and dirTx, and cycles that raise host and engine strobes together, cover the access-ready condition and the precedence rules.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

  // host-side buffer movement for one cycle
  typedef enum logic [1:0] {
    HOP_NONE    = 2'd0,
    HOP_WR16    = 2'd1,
    HOP_WR8     = 2'd2,
    HOP_RDSHIFT = 2'd3
  } hostOp_e;

  // strobes from control to datapath
  typedef struct packed {
    hostOp_e hostOp;
    logic    rxPush;
  } bufStrobe_t;

endpackage

// File: rtl/byte_lane_ctrl.sv
module byte_lane_ctrl
  import ebuf_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterOn,
  input  logic             dirTx,
  input  logic             hostWrEn,
  input  logic             hostWrByte,
  input  logic             hostRdEn,
  input  logic             txPop,
  input  logic             rxPush,
  output bufStrobe_t       strb,
  output logic [IDX_W-1:0] txLane,
  output logic [IDX_W-1:0] rxLane,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             kick,
  output logic             txUnderflowClr,
  output logic             txReadyClr,
  output logic             rxOverrunClr,
  output logic             rxReadyClr,
  output logic             singleByte,
  output logic             accessReady
);

  localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(2);
  localparam logic [CNT_W-1:0] WR_LIMIT   = CNT_W'(LANES - 2);
  localparam logic [CNT_W-1:0] FULL_CNT   = CNT_W'(LANES);

  logic [CNT_W-1:0] txCountQ, rxCountQ, txNext, rxNext;
  logic hostAcc, wrOk, rdEff, popOk, pushOk;

  assign hostAcc = hostWrEn | hostRdEn;
  assign wrOk    = hostWrEn && (txCountQ <= WR_LIMIT);
  assign rdEff   = hostRdEn && !hostWrEn;
  assign popOk   = txPop && !hostAcc && (txCountQ != '0);
  assign pushOk  = rxPush && !hostAcc && (rxCountQ < FULL_CNT);

  always_comb begin
    txNext = txCountQ;
    if (wrOk) begin
      txNext = txCountQ + (hostWrByte ? CNT_W'(1) : WORD_BYTES);
    end else if (popOk) begin
      txNext = txCountQ - CNT_W'(1);
    end
  end

  always_comb begin
    rxNext = rxCountQ;
    if (rdEff) begin
      if (rxCountQ == CNT_W'(1)) begin
        rxNext = '0;
      end else if (rxCountQ > CNT_W'(1)) begin
        rxNext = rxCountQ - WORD_BYTES;
      end
    end else if (pushOk) begin
      rxNext = rxCountQ + CNT_W'(1);
    end
  end

  always_comb begin
    strb.hostOp = HOP_NONE;
    strb.rxPush = pushOk;
    if (wrOk) begin
      strb.hostOp = hostWrByte ? HOP_WR8 : HOP_WR16;
    end else if (rdEff && (rxCountQ > WORD_BYTES)) begin
      strb.hostOp = HOP_RDSHIFT;
    end
  end

  // lane of the oldest transmit byte; don't-care when empty
  logic [CNT_W-1:0] txTop;
  assign txTop  = (txCountQ == '0) ? '0 : txCountQ - CNT_W'(1);
  assign txLane = txTop[IDX_W-1:0];
  assign rxLane = rxCountQ[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCountQ       <= '0;
      rxCountQ       <= '0;
      kick           <= 1'b0;
      txUnderflowClr <= 1'b0;
      txReadyClr     <= 1'b0;
      rxOverrunClr   <= 1'b0;
      rxReadyClr     <= 1'b0;
      singleByte     <= 1'b0;
      accessReady    <= 1'b0;
    end else begin
      txCountQ       <= txNext;
      rxCountQ       <= rxNext;
      kick           <= hostAcc;
      txUnderflowClr <= wrOk;
      txReadyClr     <= wrOk && (txNext > WORD_BYTES);
      rxOverrunClr   <= rdEff;
      rxReadyClr     <= rdEff && (rxNext == '0);
      singleByte     <= rdEff && (rxCountQ == CNT_W'(1));
      accessReady    <= rdEff && (rxNext == '0) && masterOn && !dirTx;
    end
  end

  assign txCount = txCountQ;
  assign rxCount = rxCountQ;

endmodule

// File: rtl/byte_lane_dp.sv
module byte_lane_dp
  import ebuf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int HOST_W = 2 * BYTE_W,
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strb,
  input  logic              bigEndian,
  input  logic [HOST_W-1:0] wrData,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [IDX_W-1:0]  txLane,
  input  logic [IDX_W-1:0]  rxLane,
  output logic [HOST_W-1:0] rdData,
  output logic [BYTE_W-1:0] txByte
);

  logic [BYTE_W-1:0] laneQ [LANES];
  logic [BYTE_W-1:0] up2 [LANES];
  logic [BYTE_W-1:0] up1 [LANES];
  logic [BYTE_W-1:0] dn2 [LANES];
  logic [BYTE_W-1:0] ldHi, ldLo;

  // word placement into lanes 1 and 0
  assign ldHi = bigEndian ? wrData[HOST_W-1:BYTE_W] : wrData[BYTE_W-1:0];
  assign ldLo = bigEndian ? wrData[BYTE_W-1:0] : wrData[HOST_W-1:BYTE_W];

  for (genvar i = 0; i < LANES; i++) begin : g_src
    if (i >= 2) begin : g_up2
      assign up2[i] = laneQ[i-2];
    end else if (i == 1) begin : g_ldhi
      assign up2[i] = ldHi;
    end else begin : g_ldlo
      assign up2[i] = ldLo;
    end
    if (i >= 1) begin : g_up1
      assign up1[i] = laneQ[i-1];
    end else begin : g_byte
      assign up1[i] = wrData[BYTE_W-1:0];
    end
    if (i + 2 < LANES) begin : g_dn2
      assign dn2[i] = laneQ[i+2];
    end else begin : g_fill
      assign dn2[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) laneQ[i] <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        unique case (strb.hostOp)
          HOP_WR16:    laneQ[i] <= up2[i];
          HOP_WR8:     laneQ[i] <= up1[i];
          HOP_RDSHIFT: laneQ[i] <= dn2[i];
          default: begin
            if (strb.rxPush && (rxLane == IDX_W'(i))) begin
              laneQ[i] <= laneQ[i] | rxByte;
            end
          end
        endcase
      end
    end
  end

  assign rdData = bigEndian ? {laneQ[0], laneQ[1]} : {laneQ[1], laneQ[0]};
  assign txByte = laneQ[txLane];

endmodule

// File: rtl/byte_lane_buf.sv
module byte_lane_buf
  import ebuf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int HOST_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic              masterOn,
  input  logic              dirTx,
  input  logic              hostWrEn,
  input  logic              hostWrByte,
  input  logic [HOST_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [HOST_W-1:0] hostRdData,
  input  logic              txPop,
  output logic [BYTE_W-1:0] txByte,
  input  logic              rxPush,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              kick,
  output logic              txUnderflowClr,
  output logic              txReadyClr,
  output logic              rxOverrunClr,
  output logic              rxReadyClr,
  output logic              singleByte,
  output logic              accessReady
);

  localparam int IDX_W = $clog2(LANES);

  bufStrobe_t       strb;
  logic [IDX_W-1:0] txLane, rxLane;

  byte_lane_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterOn(masterOn), .dirTx(dirTx),
    .hostWrEn(hostWrEn), .hostWrByte(hostWrByte), .hostRdEn(hostRdEn),
    .txPop(txPop), .rxPush(rxPush), .strb(strb),
    .txLane(txLane), .rxLane(rxLane),
    .txCount(txCount), .rxCount(rxCount), .kick(kick),
    .txUnderflowClr(txUnderflowClr), .txReadyClr(txReadyClr),
    .rxOverrunClr(rxOverrunClr), .rxReadyClr(rxReadyClr),
    .singleByte(singleByte), .accessReady(accessReady)
  );

  byte_lane_dp #(.BYTE_W(BYTE_W), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bigEndian(bigEndian),
    .wrData(hostWrData), .rxByte(rxByte),
    .txLane(txLane), .rxLane(rxLane),
    .rdData(hostRdData), .txByte(txByte)
  );

endmodule

// File: rtl/byte_lane_buf_chk.sv
module byte_lane_buf_chk #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             masterOn,
  input logic             dirTx,
  input logic             hostWrEn,
  input logic             hostRdEn,
  input logic             txPop,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             kick,
  input logic             txUnderflowClr,
  input logic             rxOverrunClr,
  input logic             rxReadyClr,
  input logic             singleByte,
  input logic             accessReady
);

  localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(LANES - 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LANES);

  // R5
  wr_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && txCount > WR_LIMIT) |=> ($stable(txCount) && !txUnderflowClr));

  // R12
  kick_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn || hostRdEn) |=> kick);

  // R12
  kick_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn || hostRdEn) |=> !kick);

  // R9
  lone_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && rxCount == CNT_W'(1)) |=> (singleByte && rxCount == '0));

  // R11
  rd_overrun_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn) |=> rxOverrunClr);

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && !hostWrEn && !hostRdEn && txCount == '0) |=> (txCount == '0));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL_CNT) && (rxCount <= FULL_CNT));

  // R10
  access_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessReady |-> (rxReadyClr && $past(masterOn) && !$past(dirTx)));

endmodule

bind byte_lane_buf byte_lane_buf_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (.*);

// File: tb/byte_lane_buf_bench.sv
`timescale 1ns/1ps
module byte_lane_buf_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bigEndian = 1'b0, masterOn = 1'b0, dirTx = 1'b0;
  logic hostWrEn = 1'b0, hostWrByte = 1'b0, hostRdEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic txPop = 1'b0, rxPush = 1'b0;
  logic [7:0] txByte;
  logic [7:0] rxByte = '0;
  logic [2:0] txCount, rxCount;
  logic kick, txUnderflowClr, txReadyClr, rxOverrunClr, rxReadyClr, singleByte, accessReady;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] mBuf = '0;
  int mTx = 0;
  int mRx = 0;

  always #2.5 clk = ~clk;

  byte_lane_buf u_byte_lane_buf (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .masterOn(masterOn), .dirTx(dirTx),
    .hostWrEn(hostWrEn), .hostWrByte(hostWrByte), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .txPop(txPop), .txByte(txByte),
    .rxPush(rxPush), .rxByte(rxByte), .txCount(txCount), .rxCount(rxCount),
    .kick(kick), .txUnderflowClr(txUnderflowClr), .txReadyClr(txReadyClr),
    .rxOverrunClr(rxOverrunClr), .rxReadyClr(rxReadyClr),
    .singleByte(singleByte), .accessReady(accessReady)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lane(input logic [31:0] b, input int i);
    return b[i*8 +: 8];
  endfunction

  // one cycle: drive at negedge, check combinational views, then registered results
  task automatic step(input bit wr, input bit wr8, input bit rd, input bit pop,
                      input bit push, input logic [15:0] d, input logic [7:0] rb);
    bit acc, wrOk, rdEff, popOk, pushOk, single;
    int nTx, nRx;
    logic [31:0] nBuf;
    logic [15:0] expRd;
    string tagW, tagE;
    hostWrEn = wr; hostWrByte = wr8; hostRdEn = rd; txPop = pop; rxPush = push;
    hostWrData = d; rxByte = rb;
    acc    = wr || rd;
    wrOk   = wr && (mTx <= 2);
    rdEff  = rd && !wr;
    popOk  = pop && !acc && (mTx > 0);
    pushOk = push && !acc && (mRx < 4);
    tagW   = wr8 ? "R4" : "R2";
    tagE   = (acc && (pop || push)) || (wr && rd) ? "R13" : "R6";
    #1;
    expRd = bigEndian ? {lane(mBuf, 0), lane(mBuf, 1)} : {lane(mBuf, 1), lane(mBuf, 0)};
    if (rd) chk("R8 read data", hostRdData, expRd);
    if (popOk) chk("R3/R6 tx byte", txByte, lane(mBuf, mTx - 1));
    nBuf = mBuf; nTx = mTx; nRx = mRx; single = 1'b0;
    if (wrOk) begin
      if (wr8) begin
        nBuf = {mBuf[23:0], d[7:0]}; nTx = mTx + 1;
      end else begin
        nBuf = bigEndian ? {mBuf[15:0], d[15:8], d[7:0]} : {mBuf[15:0], d[7:0], d[15:8]};
        nTx = mTx + 2;
      end
    end else if (rdEff) begin
      if (mRx == 1) begin nRx = 0; single = 1'b1; end
      else if (mRx > 1) begin
        if (mRx > 2) nBuf = {16'h0000, mBuf[31:16]};
        nRx = mRx - 2;
      end
    end else begin
      if (popOk) nTx = mTx - 1;
      if (pushOk) begin
        nBuf = mBuf | ({24'h0, rb} << (8 * mRx)); nRx = mRx + 1;
      end
    end
    @(posedge clk); #1;
    if (wr && !wrOk) chk("R5 tx count held", txCount, nTx);
    else if (wr) chk({tagW, " tx count"}, txCount, nTx);
    else chk({tagE, " tx count"}, txCount, nTx);
    chk(rd ? "R9 rx count" : (acc && push ? "R13 rx count" : "R7 rx count"), rxCount, nRx);
    chk(wr && !wrOk ? "R5 underflow clr" : {tagW, " underflow clr"}, txUnderflowClr, wrOk);
    chk("R2 tx ready clr", txReadyClr, wrOk && (nTx > 2));
    chk("R11 overrun clr", rxOverrunClr, rdEff);
    chk("R9 single byte", singleByte, single);
    chk("R10 rx ready clr", rxReadyClr, rdEff && (nRx == 0));
    chk("R10 access ready", accessReady, rdEff && (nRx == 0) && masterOn && !dirTx);
    chk("R12 kick", kick, acc);
    mBuf = nBuf; mTx = nTx; mRx = nRx;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrByte = 1'b0; hostRdEn = 1'b0; txPop = 1'b0; rxPush = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx count", txCount, 0);
    chk("R1 rx count", rxCount, 0);
    chk("R1 events", {kick, txUnderflowClr, txReadyClr, rxOverrunClr, rxReadyClr,
                      singleByte, accessReady}, 0);
    chk("R1 read data", hostRdData, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int be = 0; be < 2; be++) begin
      bigEndian = be[0];
      // word loads, overfull writes, pops in order, pop at empty
      step(1, 0, 0, 0, 0, 16'hA1B2 ^ 16'(be), 8'h00);
      step(1, 0, 0, 0, 0, 16'hC3D4, 8'h00);
      step(1, 0, 0, 0, 0, 16'hE5F6, 8'h00);
      step(1, 1, 0, 0, 0, 16'h0077, 8'h00);
      for (int k = 0; k < 5; k++) step(0, 0, 0, 1, 0, 16'h0, 8'h00);
      // trailing bytes, then a full word on top of three held
      step(1, 1, 0, 0, 0, 16'h0011, 8'h00);
      step(1, 1, 0, 0, 0, 16'h0022, 8'h00);
      step(1, 1, 0, 0, 0, 16'h0033, 8'h00);
      step(1, 0, 0, 0, 0, 16'h4455, 8'h00);
      step(1, 1, 0, 0, 0, 16'h0066, 8'h00);
      for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 16'h0, 8'h00);
      // word then byte mix
      step(1, 0, 0, 0, 0, 16'h1357, 8'h00);
      step(1, 1, 0, 0, 0, 16'h009B, 8'h00);
      for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 16'h0, 8'h00);
      // receive: every fill level, one push past full, then drain plus an empty read
      for (int n = 0; n <= 5; n++) begin
        for (int k = 0; k < n; k++)
          step(0, 0, 0, 0, 1, 16'h0, 8'((k + 1) * 8'h21 + n * 3 + be));
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 16'h0, 8'h00);
      end
    end

    // access-ready condition sweep
    for (int m = 0; m < 2; m++) begin
      for (int dt = 0; dt < 2; dt++) begin
        masterOn = m[0]; dirTx = dt[0];
        step(0, 0, 0, 0, 1, 16'h0, 8'h5A);
        step(0, 0, 0, 0, 1, 16'h0, 8'hC3);
        step(0, 0, 1, 0, 0, 16'h0, 8'h00);
        step(0, 0, 0, 0, 1, 16'h0, 8'h0F);
        step(0, 0, 1, 0, 0, 16'h0, 8'h00);
      end
    end

    // R13 precedence: write over read, host over engine
    masterOn = 1'b1; dirTx = 1'b0;
    step(0, 0, 0, 0, 1, 16'h0, 8'h81);
    step(1, 0, 1, 0, 0, 16'hBEEF, 8'h00);
    step(1, 1, 0, 1, 1, 16'h0042, 8'h99);
    step(0, 0, 1, 1, 1, 16'h0, 8'h77);
    step(0, 0, 1, 0, 0, 16'h0, 8'h00);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 1, 16'h0, 8'(8'h10 + k));
    step(0, 0, 1, 0, 0, 16'h0, 8'h00);
    step(0, 0, 1, 0, 0, 16'h0, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule